// File: doc/BRIEF.md
# Multi-mode pattern bank translator

This block turns a 13-bit pattern-table fetch address from the picture unit into an address in the character ROM. Eight 16-bit bank registers hold bank numbers. A 2-bit mode divides the 8 KB pattern space into one, two, four or eight windows, and each window takes its bank number from one of the registers. The processor loads each register one byte at a time through a write port.

Two options change which bank number is used. The first is an outer-block field of five bits, placed above the low byte of each register. The second is a flag that makes every bank number use all 16 register bits instead. A mirror flag makes the second quarter of the space reuse the first register pair when the windows are 2 KB or 1 KB wide. The ROM address is the bank number times the window size, plus the offset within the window, cut to the ROM address width.

Top module: `pattern_bank_xlat`

## Requirements
- R1: A write whose address has bits [15:12] = 9 replaces bits [7:0] of bank register cpu_addr[2:0]. Address bits [11:3] are ignored.
- R2: A write whose address has bits [15:12] = 0xA replaces bits [15:8] of bank register cpu_addr[2:0]. Address bits [11:3] are ignored.
- R3: A write to page 0xD with cpu_addr[2:0] = 0 sets the mode from data bits [4:3]: 0 gives one 8 KB window, 1 gives 4 KB, 2 gives 2 KB, 3 gives 1 KB. The other data bits have no effect.
- R4: A write to page 0xD with cpu_addr[2:0] = 3 sets the mirror flag from data[7], the full-width flag from data[5] and the outer block from data[4:0].
- R5: While the full-width flag is 0, the bank number is {outer block, register[7:0]}. The register's high byte has no effect.
- R6: While the full-width flag is 1, the bank number is all 16 bits of the register.
- R7: In mode 0, register 0 supplies the bank number for the whole space.
- R8: In mode 1, register 0 serves 0x0000–0x0FFF and register 4 serves 0x1000–0x1FFF.
- R9: In mode 2, the 2 KB windows use registers 0, 2, 4 and 6 in order. With the mirror flag set, the window at 0x0800 uses register 0.
- R10: In mode 3, 1 KB window k uses register k. With the mirror flag set, window 2 uses register 0 and window 3 uses register 1.
- R11: After reset, register i holds i, the mode is 0, and the mirror flag, full-width flag and outer block are all 0.
- R12: rom_addr is (bank number × window size + offset within the window) modulo 2^ROM_AW.
- R13: A write to any other page, or to page 0xD with cpu_addr[2:0] other than 0 or 3, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 16 | Write address |
| cpu_wr_data | input | 8 | Write data |
| ppu_addr | input | 13 | Pattern-table fetch address |
| rom_addr | output | ROM_AW | Character ROM address (combinational) |

## Verification
The bench goes after the register decode with the don't-care address bits set. A design that decodes those bits would drop the write or send it to the wrong register. It then switches the mirror flag on and off in both the 2 KB and 1 KB modes. A design that mirrors the wrong window, or mirrors in mode 1, returns data from the wrong bank for one quarter of the space. Loading register high bytes while the full-width flag is clear catches a design that lets the high byte leak into the bank number. A bank number of 0xFFFF in 8 KB mode checks the cut to the ROM width. Writes to unused pages and sub-addresses must leave every window unchanged.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    typedef enum logic [1:0] {
        PM_8K = 2'd0,
        PM_4K = 2'd1,
        PM_2K = 2'd2,
        PM_1K = 2'd3
    } pat_mode_e;

    localparam int OUTER_W = 5;

    typedef struct packed {
        pat_mode_e           mode;
        logic                mirror;
        logic                full;
        logic [OUTER_W-1:0]  outer;
    } pbx_cfg_t;

endpackage

// File: rtl/pbx_regfile.sv
module pbx_regfile
    import pbx_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int REG_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [15:0]                wr_addr,
    input  logic [7:0]                 wr_data,
    output logic [NREG-1:0][REG_W-1:0] bank_o,
    output pbx_cfg_t                   cfg_o
);
    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] bank;
        pbx_cfg_t                   cfg;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        for (int i = 0; i < NREG; i++) begin
            s.bank[i] = REG_W'(i);
        end
        s.cfg.mode   = PM_8K;
        s.cfg.mirror = 1'b0;
        s.cfg.full   = 1'b0;
        s.cfg.outer  = '0;
        return s;
    endfunction

    state_t st_d, st_q;

    logic [3:0]       page;
    logic [IDX_W-1:0] sel;
    logic             unused_addr;

    assign page        = wr_addr[15:12];
    assign sel         = wr_addr[IDX_W-1:0];
    assign unused_addr = ^wr_addr[11:IDX_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (page)
                4'h9: st_d.bank[sel][7:0]       = wr_data;
                4'hA: st_d.bank[sel][REG_W-1:8] = wr_data[REG_W-9:0];
                4'hD: begin
                    if (sel == IDX_W'(0)) begin
                        st_d.cfg.mode = pat_mode_e'(wr_data[4:3]);
                    end else if (sel == IDX_W'(3)) begin
                        st_d.cfg.mirror = wr_data[7];
                        st_d.cfg.full   = wr_data[5];
                        st_d.cfg.outer  = wr_data[OUTER_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.bank;
    assign cfg_o  = st_q.cfg;

    p_lo_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h9)
        |=> st_q.bank[$past(wr_addr[IDX_W-1:0])][7:0] == $past(wr_data));

    p_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hA)
        |=> st_q.bank[$past(wr_addr[IDX_W-1:0])][15:8] == $past(wr_data));

    p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hD && wr_addr[2:0] == 3'd0)
        |=> cfg_o.mode == pat_mode_e'($past(wr_data[4:3])));

    p_cfg_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hD && wr_addr[2:0] == 3'd3)
        |=> (cfg_o.mirror == $past(wr_data[7])) && (cfg_o.full == $past(wr_data[5])));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(st_q.bank) && $stable(st_q.cfg)));

endmodule

// File: rtl/pbx_window_sel.sv
module pbx_window_sel
    import pbx_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  pat_mode_e               mode,
    input  logic                    mirror,
    input  logic [2:0]              win,
    output logic [$clog2(NREG)-1:0] idx_o
);
    localparam int IDX_W = $clog2(NREG);

    logic [2:0] idx_raw;

    always_comb begin
        unique case (mode)
            PM_8K: idx_raw = 3'd0;
            PM_4K: idx_raw = {win[2], 2'b00};
            PM_2K: idx_raw = {win[2:1], 1'b0};
            PM_1K: idx_raw = win;
            default: idx_raw = 3'd0;
        endcase
        if (mirror && (mode == PM_2K || mode == PM_1K) && idx_raw[2:1] == 2'b01) begin
            idx_raw[1] = 1'b0;
        end
        idx_o = IDX_W'(idx_raw);
    end

    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_8K) |-> (idx_o == '0));

    p_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_4K) |-> (idx_o == (win[2] ? IDX_W'(4) : IDX_W'(0))));

    p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_2K && mirror) |-> (idx_o != IDX_W'(2)));

    p_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_1K && mirror && win[2:1] == 2'b01) |-> (idx_o == IDX_W'({2'b00, win[0]})));

endmodule

// File: rtl/pbx_addr_gen.sv
module pbx_addr_gen
    import pbx_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int PPU_AW = 13,
    parameter int ROM_AW = 20
) (
    input  logic [REG_W-1:0]   reg_val,
    input  pbx_cfg_t           cfg,
    input  logic [PPU_AW-1:0]  ppu_addr,
    output logic [ROM_AW-1:0]  rom_addr
);
    localparam int WIDE_W = REG_W + PPU_AW;
    localparam int PAD_W  = REG_W - 8 - OUTER_W;

    logic [REG_W-1:0]  bank_num;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        if (cfg.full) begin
            bank_num = reg_val;
        end else begin
            bank_num = {{PAD_W{1'b0}}, cfg.outer, reg_val[7:0]};
        end
    end

    always_comb begin
        unique case (cfg.mode)
            PM_8K: wide = {bank_num, ppu_addr[PPU_AW-1:0]};
            PM_4K: wide = {1'b0, bank_num, ppu_addr[PPU_AW-2:0]};
            PM_2K: wide = {2'b00, bank_num, ppu_addr[PPU_AW-3:0]};
            PM_1K: wide = {3'b000, bank_num, ppu_addr[PPU_AW-4:0]};
            default: wide = '0;
        endcase
    end

    assign rom_addr = wide[ROM_AW-1:0];

    generate
        if (ROM_AW < WIDE_W) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^wide[WIDE_W-1:ROM_AW];
        end
    endgenerate

endmodule

// File: rtl/pattern_bank_xlat.sv
module pattern_bank_xlat
    import pbx_pkg::*;
#(
    parameter int ROM_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wr_data,
    input  logic [12:0]       ppu_addr,
    output logic [ROM_AW-1:0] rom_addr
);
    localparam int NREG   = 8;
    localparam int REG_W  = 16;
    localparam int PPU_AW = 13;
    localparam int IDX_W  = $clog2(NREG);

    logic [NREG-1:0][REG_W-1:0] bank;
    pbx_cfg_t                   cfg;
    logic [IDX_W-1:0]           idx;

    pbx_regfile #(.NREG(NREG), .REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cpu_wr_en),
        .wr_addr (cpu_addr),
        .wr_data (cpu_wr_data),
        .bank_o  (bank),
        .cfg_o   (cfg)
    );

    pbx_window_sel #(.NREG(NREG)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (cfg.mode),
        .mirror (cfg.mirror),
        .win    (ppu_addr[12:10]),
        .idx_o  (idx)
    );

    pbx_addr_gen #(.REG_W(REG_W), .PPU_AW(PPU_AW), .ROM_AW(ROM_AW)) u_gen (
        .reg_val  (bank[idx]),
        .cfg      (cfg),
        .ppu_addr (ppu_addr),
        .rom_addr (rom_addr)
    );

    p_offset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[9:0] == ppu_addr[9:0]);

endmodule

// File: tb/pattern_bank_xlat_tb_top.sv
`timescale 1ns/1ps
module pattern_bank_xlat_tb_top;
    localparam int ROM_AW = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_wr_en = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wr_data = '0;
    logic [12:0]       ppu_addr = '0;
    logic [ROM_AW-1:0] rom_addr;

    int tests = 0;
    int fails = 0;

    int m_reg [8];
    int m_mode, m_mir, m_full, m_outer;

    always #2.5 clk = ~clk;

    pattern_bank_xlat #(.ROM_AW(ROM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wr_data(cpu_wr_data), .ppu_addr(ppu_addr), .rom_addr(rom_addr)
    );

    function automatic longint model_addr(int p);
        int size, w, r, v;
        size = 8192 >> m_mode;
        w = p / size;
        r = (m_mode == 0) ? 0 : (m_mode == 1) ? w * 4 : (m_mode == 2) ? w * 2 : w;
        if (m_mir != 0 && m_mode >= 2 && (r == 2 || r == 3)) r = r - 2;
        v = (m_full != 0) ? m_reg[r] : ((m_outer * 256) + (m_reg[r] % 256));
        return (longint'(v) * size + (p % size)) % (longint'(1) << ROM_AW);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = i;
        m_mode = 0; m_mir = 0; m_full = 0; m_outer = 0;
    endtask

    task automatic cpu_write(input int a, input int d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = 16'(a); cpu_wr_data = 8'(d);
        @(negedge clk);
        cpu_wr_en = 1'b0;
        case ((a >> 12) & 15)
            9:  m_reg[a & 7] = (m_reg[a & 7] & 16'hFF00) | (d & 255);
            10: m_reg[a & 7] = (m_reg[a & 7] & 255) | ((d & 255) << 8);
            13: begin
                if ((a & 7) == 0) m_mode = (d >> 3) & 3;
                else if ((a & 7) == 3) begin
                    m_mir = (d >> 7) & 1; m_full = (d >> 5) & 1; m_outer = d & 31;
                end
            end
            default: ;
        endcase
    endtask

    task automatic check(input int p, input string req);
        longint exp;
        @(negedge clk);
        ppu_addr = 13'(p);
        #1;
        exp = model_addr(p);
        tests++;
        if (longint'(rom_addr) != exp) begin
            fails++;
            $display("FAIL %s ppu=%h actual=%h expected=%h", req, p, rom_addr, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int w = 0; w < 8; w++) check(w * 1024 + 16'h155 + w * 3, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(16'h1234, "R11 reset mode0");
        check(16'h0000, "R11 reset mode0 base");
        cpu_write(16'hD000, 8'h18);
        sweep("R11 reset regs / R10 mode3");
        cpu_write(16'hD000, 8'hE7);
        check(16'h1ABC, "R3 mode from bits 4:3 only");
        for (int i = 0; i < 8; i++) cpu_write(16'h9FF8 | i, 8'h20 + i * 5);
        for (int i = 0; i < 8; i++) cpu_write(16'hA7F8 | i, 8'h01 + i);
        cpu_write(16'hD000, 8'h18);
        sweep("R1 R2 R5 low byte, high byte ignored");
        cpu_write(16'hD003, 8'h15);
        sweep("R4 R5 outer block");
        cpu_write(16'hD003, 8'h3F);
        sweep("R6 full width");
        cpu_write(16'hD003, 8'hA9);
        sweep("R10 mirror mode3");
        cpu_write(16'hD000, 8'h10);
        sweep("R9 mirror mode2");
        cpu_write(16'hD003, 8'h29);
        sweep("R9 mode2 no mirror");
        cpu_write(16'hD003, 8'h8A);
        cpu_write(16'hD000, 8'h08);
        sweep("R8 mode1 mirror inert");
        cpu_write(16'hD000, 8'h00);
        sweep("R7 mode0");
        cpu_write(16'h8000, 8'h55);
        cpu_write(16'hB001, 8'h77);
        cpu_write(16'hC000, 8'h18);
        cpu_write(16'hD001, 8'h18);
        cpu_write(16'hD002, 8'hFF);
        cpu_write(16'hE003, 8'hFF);
        sweep("R13 ignored writes");
        cpu_write(16'hD000, 8'h18);
        sweep("R13 ignored writes mode3");
        cpu_write(16'h9000, 8'hFF);
        cpu_write(16'hA000, 8'hFF);
        cpu_write(16'hD003, 8'h20);
        cpu_write(16'hD000, 8'h00);
        check(16'h1FFF, "R12 wrap 8K");
        check(16'h0123, "R12 wrap 8K low");
        cpu_write(16'hD000, 8'h18);
        check(16'h03FF, "R12 wrap 1K");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule